// File: doc/BRIEF.md
# Interrupt Eligibility Bank

This block tracks thirty-two interrupt lines and works out, every clock, which of them may be handed to a CPU interface. It keeps per-line state: a pending latch, a trigger mode, an enable, an active flag, a group bit and a group modifier. It samples the raw interrupt inputs and holds a small global control register. The control register has a security-disable bit and three group enables: group 0, secure group 1 and non-secure group 1.

A line is eligible when three conditions hold. It must be pending, either latched or held high as a level input. It must be enabled and not active. Its group class must be switched on. The block presents the result as a registered 32-bit mask. A simple write port loads each bitmap. Separate set and clear vectors act on the pending latch, as software would. A downstream priority selector reads the mask.

Top module: `irq_elig_bank`

## Requirements
- R1: Trigger-mode bit 1 means edge and 0 means level. A line counts as pending when its latch is set, or when it is level-triggered and its sampled input is high. A level line that is not latched stops counting once its input falls.
- R2: A pending line is eligible only when its enable bit is 1 and its active bit is 0.
- R3: When control bit 3 (security disable) is 1, every group modifier bit is taken as 0.
- R4: When control bit 2 (non-secure group 1 enable) is 1, lines with group bit 1 pass the group filter.
- R5: When control bit 1 (secure group 1 enable) is 1, lines with group bit 0 and effective modifier 1 pass the group filter.
- R6: When control bit 0 (group 0 enable) is 1, lines with group bit 0 and effective modifier 0 pass the group filter.
- R7: The eligible mask is the pending, enabled and not-active mask ANDed with the union of the enabled group filters. When control bits 2..0 are all 0, the mask is zero.
- R8: On an edge-triggered line, a rising edge of the input sets the pending latch. The latch stays set after the input falls.
- R9: Bits of `pend_set` set the latch and bits of `pend_clr` clear it, both on the next clock. A clear wins over a simultaneous set, a simultaneous edge or a write of the pending bitmap.
- R10: Reset clears every bitmap and the control register, so the eligible mask reads zero during reset and after it.
- R11: The output is registered. A change of stored state shows on `elig` one clock after it is stored. A set pulse shows on the second rising edge after it is driven. An input level change shows on the second rising edge, and an edge reaches the mask on the third.
- R12: When `wr_en` is 1, `wr_sel` picks the target: 0 trigger mode, 1 enable, 2 active, 3 group, 4 modifier, 5 pending latch and 6 control (`wr_data[3:0]`). The whole target is replaced on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected bitmap |
| wr_sel | input | 3 | Target of the write (see R12) |
| wr_data | input | 32 | Write value |
| pend_set | input | 32 | Per-line pending set |
| pend_clr | input | 32 | Per-line pending clear |
| irq_in | input | 32 | Raw interrupt input levels |
| elig | output | 32 | Registered eligible mask |

## Verification
A wrong internal state shows at the ports one or two clocks after it arises. A pending latch that fails to set or clear, or an enable or active bit that is lost, flips the matching bit of `elig` on the next edge. A wrong group or modifier bit hides only under some control settings. The stimulus therefore sweeps each group class alone, with and without security disable. Edge capture passes through two input flops, so a lost edge shows up three clocks after the input rises.

// File: rtl/irq_elig_bank.sv
module irq_elig_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] pend_set,
  input  logic [N-1:0] pend_clr,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] elig
);

  localparam logic [2:0] SEL_TRIG = 3'd0;
  localparam logic [2:0] SEL_EN   = 3'd1;
  localparam logic [2:0] SEL_ACT  = 3'd2;
  localparam logic [2:0] SEL_GRP  = 3'd3;
  localparam logic [2:0] SEL_MOD  = 3'd4;
  localparam logic [2:0] SEL_PEND = 3'd5;
  localparam logic [2:0] SEL_CTL  = 3'd6;

  logic [N-1:0] trig_q, en_q, act_q, grp_q, mod_q, pend_q;
  logic [N-1:0] lvl_q, prev_q, elig_q;
  logic [3:0]   ctl_q;

  logic [N-1:0] rise, pend_base, pend_nx;
  logic [N-1:0] raw_pend, live, mod_eff, gmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      en_q   <= '0;
      act_q  <= '0;
      grp_q  <= '0;
      mod_q  <= '0;
      ctl_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_TRIG: trig_q <= wr_data;
        SEL_EN:   en_q   <= wr_data;
        SEL_ACT:  act_q  <= wr_data;
        SEL_GRP:  grp_q  <= wr_data;
        SEL_MOD:  mod_q  <= wr_data;
        SEL_CTL:  ctl_q  <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  assign rise      = lvl_q & ~prev_q & trig_q;
  assign pend_base = (wr_en && wr_sel == SEL_PEND) ? wr_data : pend_q;
  assign pend_nx   = (pend_base | pend_set | rise) & ~pend_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_nx;
      lvl_q  <= irq_in;
      prev_q <= lvl_q;
    end
  end

  assign raw_pend = pend_q | (~trig_q & lvl_q);
  assign live     = raw_pend & en_q & ~act_q;
  assign mod_eff  = ctl_q[3] ? '0 : mod_q;
  assign gmask    = ({N{ctl_q[2]}} & grp_q)
                  | ({N{ctl_q[1]}} & ~grp_q & mod_eff)
                  | ({N{ctl_q[0]}} & ~grp_q & ~mod_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_q <= '0;
    else        elig_q <= live & gmask;
  end

  assign elig = elig_q;

endmodule

// File: rtl/irq_elig_bank_chk.sv
module irq_elig_bank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] en_q,
  input logic [N-1:0] act_q,
  input logic [N-1:0] grp_q,
  input logic [N-1:0] mod_q,
  input logic [N-1:0] pend_q,
  input logic [3:0]   ctl_q,
  input logic [N-1:0] pend_clr,
  input logic [N-1:0] elig
);

  assert_active_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elig & $past(act_q)) == '0);

  assert_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elig & ~$past(en_q)) == '0);

  assert_secdis_g1s_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[3] && ctl_q[2:0] == 3'b010) |=> elig == '0);

  assert_g1ns_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(elig & $past(grp_q))) |-> $past(ctl_q[2]));

  assert_g1s_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(elig & ~$past(grp_q) & $past(mod_q))) && !$past(ctl_q[3])) |-> $past(ctl_q[1]));

  assert_no_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[2:0] == 3'b000) |=> elig == '0);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_clr) |=> (pend_q & $past(pend_clr)) == '0);

endmodule

bind irq_elig_bank irq_elig_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .act_q(act_q), .grp_q(grp_q),
  .mod_q(mod_q), .pend_q(pend_q), .ctl_q(ctl_q), .pend_clr(pend_clr),
  .elig(elig)
);

// File: tb/sim_irq_elig_bank.sv
module sim_irq_elig_bank;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = '0;
  logic [N-1:0] wr_data = '0, pend_set = '0, pend_clr = '0, irq_in = '0;
  logic [N-1:0] elig;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_elig_bank #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pend_set(pend_set), .pend_clr(pend_clr), .irq_in(irq_in), .elig(elig)
  );

  // {ctl[3:0], trig, en, act, grp, mod, pend, lvl, exp} per byte, replicated x4
  localparam logic [67:0] VEC [10] = '{
    {4'h7, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hFF}, // R1 R6
    {4'h4, 8'hF0, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h0F}, // R1 R4
    {4'h4, 8'h00, 8'hF0, 8'hCC, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h30}, // R2
    {4'h2, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h50, 8'hFF, 8'h00, 8'h50}, // R5
    {4'h1, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h50, 8'hFF, 8'h00, 8'hA0}, // R6
    {4'h4, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h50, 8'hFF, 8'h00, 8'h0F}, // R4
    {4'hA, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h50, 8'hFF, 8'h00, 8'h00}, // R3
    {4'h9, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h50, 8'hFF, 8'h00, 8'hF0}, // R3
    {4'h0, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h50, 8'hFF, 8'h00, 8'h00}, // R7
    {4'h7, 8'h00, 8'hFF, 8'h00, 8'h0F, 8'h50, 8'hFF, 8'h00, 8'hFF}  // R7
  };

  task automatic chk(input string req, input logic [N-1:0] exp);
    checks++;
    if (elig !== exp) begin
      fails++;
      $display("FAIL %s: elig=%h expected=%h", req, elig, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    irq_in = '1;
    idle(3);
    chk("R10 during reset", '0);
    rst_n = 1'b1;
    idle(3);
    chk("R10 after reset", '0);

    // R12 write port used for every bitmap in the table walk
    for (int i = 0; i < 10; i++) begin
      irq_in = '0;
      idle(3);
      wr(3'd6, {28'd0, VEC[i][67:64]});
      wr(3'd0, {4{VEC[i][63:56]}});
      wr(3'd1, {4{VEC[i][55:48]}});
      wr(3'd2, {4{VEC[i][47:40]}});
      wr(3'd3, {4{VEC[i][39:32]}});
      wr(3'd4, {4{VEC[i][31:24]}});
      irq_in = {4{VEC[i][15:8]}};
      idle(3);
      wr(3'd5, {4{VEC[i][23:16]}});
      idle(2);
      chk($sformatf("R12 R7 vector %0d", i), {4{VEC[i][7:0]}});
    end

    irq_in = '0;
    idle(3);
    wr(3'd6, 32'h4);
    wr(3'd0, '1);
    wr(3'd1, '1);
    wr(3'd2, '0);
    wr(3'd3, '1);
    wr(3'd4, '0);
    wr(3'd5, '0);
    idle(2);
    chk("R12 cleared setup", '0);

    irq_in = 32'h20;
    idle(3);
    chk("R8 edge latched", 32'h20);
    irq_in = '0;
    idle(3);
    chk("R8 latch holds after fall", 32'h20);
    pend_clr = 32'h20;
    idle(1);
    pend_clr = '0;
    idle(1);
    chk("R9 clear", '0);

    pend_set = 32'h8;
    idle(1);
    pend_set = '0;
    chk("R11 not yet visible", '0);
    idle(1);
    chk("R11 visible second edge", 32'h8);
    pend_set = 32'h8; pend_clr = 32'h8;
    idle(1);
    pend_set = '0; pend_clr = '0;
    idle(1);
    chk("R9 clear beats set", '0);

    irq_in = 32'h200; pend_clr = 32'h200;
    idle(2);
    pend_clr = '0;
    idle(3);
    chk("R9 clear beats edge", '0);

    wr(3'd0, '0);
    idle(2);
    chk("R1 level pending", 32'h200);
    irq_in = '0;
    idle(3);
    chk("R1 level not latched", '0);

    pend_set = 32'hFF;
    idle(1);
    pend_set = '0;
    idle(2);
    chk("R11 set before reset", 32'hFF);
    rst_n = 1'b0;
    idle(1);
    chk("R10 mid-run reset", '0);
    rst_n = 1'b1;
    pend_set = 32'hFF;
    idle(1);
    pend_set = '0;
    idle(2);
    chk("R10 enables cleared by reset", '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule